// File: doc/BRIEF.md
# Line Output Latch and Polarity Control

This block sits between the line-wide data register of a column driver and its analog output stage. When the horizontal strobe goes high, it copies one full line of gray codes into a holding latch. When the strobe goes low again, it presents that line to the output drivers. It also produces the digital controls for every channel's analog output: a reference-bank select, which picks the low or high half of the gamma references, and a two-bit output state.

The bank a channel uses depends on the polarity input and on whether the channel is odd or even, and the banks swap when the polarity inverts. During each strobe-high phase the outputs are taken off drive. If the polarity captured at this strobe differs from the one captured at the previous strobe, every channel goes to the reset state. Otherwise every channel floats. Two mode inputs, for slew rate and output resistance, are registered and passed to status outputs. The strobe is sampled by the block clock, and both strobe edges are detected synchronously. One strobe pulse is expected per line.

Top module: `line_out_ctrl`

## Requirements
- R1: After reset, every channel's `out_state` is 2'b00 (high-impedance), `gray_out` is all zeros, the stored polarity is 0, and `bank_hi` shows the polarity-0 pattern.
- R2: On the clock that first samples `strobe` high, the whole of `line_data` is captured. `gray_out` does not change until the strobe falls, and changes to `line_data` made after the capture do not reach the outputs.
- R3: One clock after `strobe` is first sampled low following a high phase, `gray_out` equals the captured line and every channel's `out_state` is 2'b01 (drive).
- R4: Channel k (0-based, field `gray_out[GW*k +: GW]`) has `bank_hi[k]` = P XOR (k mod 2), where P is the polarity captured at the latest strobe rise. With P=0 this gives odd-numbered channels (even k) the low bank and even-numbered channels the high bank.
- R5: If the polarity captured at a strobe rise differs from the one captured at the previous rise, every channel's `out_state` is 2'b10 (reset) from one clock after the rise until the fall is applied.
- R6: If the captured polarity equals the previous one, every channel's `out_state` is 2'b00 (high-impedance) during that strobe-high phase.
- R7: `polarity` is sampled only on the strobe-rise clock. Changes at any other time have no effect on `bank_hi` or on the reset/float choice.
- R8: `slew_fast` follows `slew_sel` and `low_res` follows `ores_sel` with one clock of delay. Both reset to 1, the not-driven default.
- R9: The first strobe after reset compares against a stored polarity of 0, so a polarity of 1 gives the reset state on that first line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe | input | 1 | Line strobe, one pulse per line |
| polarity | input | 1 | Polarity select, sampled at strobe rise |
| slew_sel | input | 1 | 1 = high slew, 0 = low slew |
| ores_sel | input | 1 | 1 = low output resistance, 0 = high |
| line_data | input | NCH*GW | Data-register contents, channel k at bits GW*k +: GW |
| gray_out | output | NCH*GW | Gray codes presented to the output drivers |
| bank_hi | output | NCH | Per channel: 1 = high reference bank |
| out_state | output | 2*NCH | Per channel: 00 float, 01 drive, 10 reset |
| slew_fast | output | 1 | Registered slew mode |
| low_res | output | 1 | Registered resistance mode |

## Verification
The hardest case to reach is a polarity that moves at the wrong time: mid-line, while the strobe is high, and then back again before the next rise. Such a change must alter neither the bank selects nor the next reset/float decision. The directed line task toggles `polarity` and scrambles `line_data` while the strobe is high. It then checks the banks and the presented data after the fall against the value captured at the rise. The first line after a fresh reset is driven with polarity 1, which reaches the comparison against the reset-time stored value.

// File: rtl/line_out_ctrl_pkg.sv
package line_out_ctrl_pkg;

  typedef enum logic [1:0] {
    OUT_HIZ   = 2'b00,
    OUT_DRIVE = 2'b01,
    OUT_RESET = 2'b10
  } out_state_e;

  // Bank select: the polarity, inverted on every other channel.
  function automatic logic bank_sel(input logic pol, input int unsigned idx);
    return pol ^ logic'(idx & 1);
  endfunction

  // State applied for a strobe-high phase.
  function automatic out_state_e strobe_state(input logic changed);
    return changed ? OUT_RESET : OUT_HIZ;
  endfunction

endpackage

// File: rtl/line_out_ctrl_edge.sv
module line_out_ctrl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise,
  output logic fall
);
  logic strb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= strobe;
  end

  assign rise = strobe & ~strb_q;
  assign fall = ~strobe & strb_q;
endmodule

// File: rtl/line_out_ctrl_latch.sv
module line_out_ctrl_latch #(
  parameter int NCH = 384,
  parameter int GW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            present,
  input  logic [NCH*GW-1:0] din,
  output logic [NCH*GW-1:0] dout
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [GW-1:0] hold_q;
    logic [GW-1:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        out_q  <= '0;
      end else begin
        if (load)    hold_q <= din[GW*k +: GW];
        if (present) out_q  <= hold_q;
      end
    end

    assign dout[GW*k +: GW] = out_q;
  end
endmodule

// File: rtl/line_out_ctrl_pol.sv
module line_out_ctrl_pol
  import line_out_ctrl_pkg::*;
#(
  parameter int NCH = 384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             polarity,
  output logic             pol_chg,
  output logic [NCH-1:0]   bank_hi,
  output logic [2*NCH-1:0] state_vec
);
  logic       pol_last;
  logic       pol_app;
  out_state_e st_q;

  assign pol_chg = polarity ^ pol_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_last <= 1'b0;
      pol_app  <= 1'b0;
      st_q     <= OUT_HIZ;
    end else if (rise) begin
      pol_last <= polarity;
      st_q     <= strobe_state(pol_chg);
    end else if (fall) begin
      pol_app  <= pol_last;
      st_q     <= OUT_DRIVE;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign bank_hi[k]        = bank_sel(pol_app, k);
    assign state_vec[2*k +: 2] = st_q;
  end
endmodule

// File: rtl/line_out_ctrl.sv
module line_out_ctrl #(
  parameter int NCH = 384,
  parameter int GW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic               polarity,
  input  logic               slew_sel,
  input  logic               ores_sel,
  input  logic [NCH*GW-1:0]  line_data,
  output logic [NCH*GW-1:0]  gray_out,
  output logic [NCH-1:0]     bank_hi,
  output logic [2*NCH-1:0]   out_state,
  output logic               slew_fast,
  output logic               low_res
);
  logic rise;
  logic fall;
  logic pol_chg;

  line_out_ctrl_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rise(rise), .fall(fall)
  );

  line_out_ctrl_latch #(.NCH(NCH), .GW(GW)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(rise), .present(fall),
    .din(line_data), .dout(gray_out)
  );

  line_out_ctrl_pol #(.NCH(NCH)) u_pol (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .polarity(polarity), .pol_chg(pol_chg),
    .bank_hi(bank_hi), .state_vec(out_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slew_fast <= 1'b1;
      low_res   <= 1'b1;
    end else begin
      slew_fast <= slew_sel;
      low_res   <= ores_sel;
    end
  end
endmodule

// File: rtl/line_out_ctrl_chk.sv
module line_out_ctrl_chk #(
  parameter int NCH = 384,
  parameter int GW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise,
  input logic              fall,
  input logic              pol_chg,
  input logic              slew_sel,
  input logic              slew_fast,
  input logic [NCH*GW-1:0] gray_out,
  input logic [NCH-1:0]    bank_hi,
  input logic [2*NCH-1:0]  out_state
);
  p_gray_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(gray_out));

  p_drive_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> out_state[1:0] == 2'b01);

  p_reset_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise && pol_chg |=> out_state[1:0] == 2'b10);

  p_float_on_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise && !pol_chg |=> out_state[1:0] == 2'b00);

  p_state_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rise && !fall |=> $stable(out_state) && $stable(bank_hi));

  p_slew_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slew_fast == $past(slew_sel));

  if (NCH >= 2) begin : g_pair
    p_bank_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_hi[0] != bank_hi[1]);
  end
endmodule

bind line_out_ctrl line_out_ctrl_chk #(.NCH(NCH), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .pol_chg(pol_chg),
  .slew_sel(slew_sel), .slew_fast(slew_fast), .gray_out(gray_out),
  .bank_hi(bank_hi), .out_state(out_state)
);

// File: tb/line_out_ctrl_test.sv
module line_out_ctrl_test;
  localparam int NCH = 4;
  localparam int GW  = 8;
  localparam int DW  = NCH * GW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, polarity = 1'b0, slew_sel = 1'b1, ores_sel = 1'b1;
  logic [DW-1:0]    line_data = '0;
  logic [DW-1:0]    gray_out;
  logic [NCH-1:0]   bank_hi;
  logic [2*NCH-1:0] out_state;
  logic slew_fast, low_res;

  int checks = 0;
  int fails  = 0;
  logic exp_pol = 1'b0;
  logic [DW-1:0] exp_gray = '0;

  always #10 clk = ~clk;

  line_out_ctrl #(.NCH(NCH), .GW(GW)) uut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .polarity(polarity),
    .slew_sel(slew_sel), .ores_sel(ores_sel), .line_data(line_data),
    .gray_out(gray_out), .bank_hi(bank_hi), .out_state(out_state),
    .slew_fast(slew_fast), .low_res(low_res)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2*NCH-1:0] all_state(input logic [1:0] s);
    logic [2*NCH-1:0] v;
    for (int k = 0; k < NCH; k++) v[2*k +: 2] = s;
    return v;
  endfunction

  function automatic logic [NCH-1:0] exp_banks(input logic p);
    logic [NCH-1:0] v;
    for (int k = 0; k < NCH; k++) v[k] = (k % 2 == 1) ? ~p : p;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; strobe = 1'b0; polarity = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_pol = 1'b0;
    exp_gray = '0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(out_state == all_state(2'b00), "R1 state", out_state, all_state(2'b00));
    chk(gray_out == '0, "R1 gray", gray_out, 0);
    chk(bank_hi == exp_banks(1'b0), "R1 bank", bank_hi, exp_banks(1'b0));
    chk(slew_fast && low_res, "R1/R8 mode default", {slew_fast, low_res}, 2'b11);
  endtask

  task automatic t_modes();
    slew_sel = 1'b0; ores_sel = 1'b1;
    @(negedge clk);
    chk({slew_fast, low_res} == 2'b01, "R8 modes a", {slew_fast, low_res}, 2'b01);
    slew_sel = 1'b1; ores_sel = 1'b0;
    @(negedge clk);
    chk({slew_fast, low_res} == 2'b10, "R8 modes b", {slew_fast, low_res}, 2'b10);
    slew_sel = 1'b1; ores_sel = 1'b1;
    @(negedge clk);
  endtask

  // One full line; polarity and data are disturbed while the strobe is high.
  task automatic t_line(input logic [DW-1:0] data, input logic pol, input string tag);
    logic [1:0] st_exp;
    st_exp = (pol != exp_pol) ? 2'b10 : 2'b00;
    line_data = data; polarity = pol; strobe = 1'b1;
    @(negedge clk);
    chk(out_state == all_state(st_exp), {tag, " R5/R6 strobe-high state"},
        out_state, all_state(st_exp));
    chk(gray_out == exp_gray, {tag, " R2 gray held"}, gray_out, exp_gray);
    exp_pol = pol;
    line_data = ~data; polarity = ~pol;
    repeat (2) @(negedge clk);
    chk(out_state == all_state(st_exp), {tag, " R7 state held"},
        out_state, all_state(st_exp));
    polarity = pol;
    strobe = 1'b0;
    @(negedge clk);
    exp_gray = data;
    chk(gray_out == exp_gray, {tag, " R3/R2 presented"}, gray_out, exp_gray);
    chk(out_state == all_state(2'b01), {tag, " R3 drive"}, out_state, all_state(2'b01));
    chk(bank_hi == exp_banks(pol), {tag, " R4/R7 bank"}, bank_hi, exp_banks(pol));
    line_data = 32'h5A5A_5A5A; polarity = ~pol;
    repeat (2) @(negedge clk);
    chk(gray_out == exp_gray, {tag, " R2 ignore between lines"}, gray_out, exp_gray);
    chk(bank_hi == exp_banks(pol), {tag, " R7 bank between lines"}, bank_hi, exp_banks(pol));
    polarity = pol;
  endtask

  task automatic t_first_after_reset();
    do_reset();
    t_line(32'hDEAD_BEEF, 1'b1, "R9 first line");
  endtask

  initial begin
    t_reset();
    t_modes();
    t_line(32'h0102_0304, 1'b0, "line0 same");
    t_line(32'hFF00_80C1, 1'b1, "line1 change");
    t_line(32'h7E7E_1234, 1'b1, "line2 same");
    t_line(32'h0000_FFFF, 1'b0, "line3 change");
    t_first_after_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule